// File: doc/BRIEF.md
# Flash read wait-state sequencer

This block sits between a simple read request port and the read port of a flash array. It decides how long to wait for the array before returning a word. In programmed mode it counts a configured number of wait states, from 0 to 15. In automatic mode it waits for a ready handshake from the array, which lets the part run at any clock rate at the cost of at least one cycle of latency.

A one-line read cache holds the last word fetched from the array. A read of the same word returns in the cycle that starts at the accepting edge, with no array access. The line is dropped the moment a program or erase operation starts. A cache-disable input sends every read to the array.

The wait count and the mode live in a small configuration register that is loaded by a write strobe. Both are sampled when a request is accepted, so reprogramming them during an access does not affect that access.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset the wait count is 0, automatic mode is on, `req_ready` is 1, and `rsp_valid` and `arr_req` are 0.
- R2: In programmed mode with wait count N, a read that misses the cache raises `rsp_valid` at the (N+1)th rising edge after the accepting edge.
- R3: In automatic mode, a miss raises `rsp_valid` at the first edge after the accepting edge at which `arr_ready` is sampled high. If the array is ready L cycles after `arr_req` rises, the latency is L+1 edges, and never less than 1.
- R4: `req_ready` is high only while no access is in progress. `rsp_valid` is a single-cycle pulse for each accepted request, and `req_ready` is high again in the cycle after the pulse.
- R5: A read whose word address (`req_addr` without its low log2(WORD_BYTES) bits) matches the valid line, with `cache_off` low, raises `rsp_valid` in the cycle that begins at the accepting edge. It returns the line data and does not raise `arr_req`.
- R6: While `cache_off` is high at acceptance, the read always goes to the array and does not fill the line.
- R7: A high `pe_start` at an edge invalidates the line. The next read of that word misses and returns the array's current data.
- R8: The wait count and the mode are sampled at the accepting edge. A configuration write during an access leaves that access's latency unchanged.
- R9: A high `cfg_we` at an edge loads `cfg_wait_d` and `cfg_auto_d`, and these values govern the following requests.
- R10: On a miss, `arr_req` rises at the accepting edge and `arr_addr` carries the word address, held stable until the completing edge. `rsp_data` equals `arr_data` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wait_d | input | WAIT_W | Wait count to load |
| cfg_auto_d | input | 1 | Automatic mode to load (1 = on) |
| cache_off | input | 1 | Bypass the line cache |
| pe_start | input | 1 | A program or erase operation starts |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data |
| arr_req | output | 1 | Array access in progress |
| arr_addr | output | ADDR_W-log2(WORD_BYTES) | Word address to the array |
| arr_ready | input | 1 | Array data ready (automatic mode) |
| arr_data | input | DATA_W | Array read data |

## Verification
Each result has a fixed due edge, counted from the edge that accepts the request:
- a cache hit is due at edge 0;
- a programmed miss is due at edge N+1;
- an automatic miss is due one edge after the array model's ready delay L, that is at edge L+1.

The bench samples at each falling edge after acceptance and records the first edge at which `rsp_valid` is seen. It compares that index, and the data, with the value its own cache and configuration model predicts. `arr_req` and `arr_addr` are checked at the first falling edge. The return of `req_ready`, and the end of the pulse, are checked one edge after the response.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_PROG = 2'd1,
      FS_AUTO = 2'd2
   } fs_state_e;

   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fseq_cfg_reg.sv
module fseq_cfg_reg #(
   parameter int unsigned WAIT_W   = 4,
   parameter int unsigned WAIT_RST = 0,
   parameter bit          AUTO_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WAIT_W-1:0] wait_d,
   input  logic              auto_d,
   output logic [WAIT_W-1:0] wait_q,
   output logic              auto_q
);

   localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(WAIT_RST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= WAIT_INIT;
         auto_q <= AUTO_RST;
      end else if (we) begin
         wait_q <= wait_d;
         auto_q <= auto_d;
      end
   end

   // R9: without a load strobe the configuration holds
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(wait_q) && $stable(auto_q)));

   // R9: a load strobe takes the offered values
   p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (wait_q == $past(wait_d) && auto_q == $past(auto_d)));

endmodule

// File: rtl/fseq_wait_ctr.sv
module fseq_wait_ctr #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (run && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

   // R2: while running, each edge removes exactly one wait state
   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R2: an exhausted counter stays at zero until reloaded
   p_stay_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt == '0) |=> zero);

endmodule

// File: rtl/fseq_line_cache.sv
module fseq_line_cache #(
   parameter int unsigned TAG_W    = 14,
   parameter int unsigned DATA_W   = 32,
   parameter bit          CACHE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  look_tag,
   input  logic              off,
   input  logic              flush,
   input  logic              fill,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   output logic              hit,
   output logic [DATA_W-1:0] line_data
);

   if (CACHE_EN) begin : g_line
      logic              valid_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            data_q  <= '0;
         end else if (flush) begin
            valid_q <= 1'b0;
         end else if (fill) begin
            valid_q <= 1'b1;
            tag_q   <= fill_tag;
            data_q  <= fill_data;
         end
      end

      assign hit       = valid_q && !off && !flush && (tag_q == look_tag);
      assign line_data = data_q;

      // R7: a program/erase start leaves no valid line behind
      p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
         flush |=> !valid_q);

      // R5: a fill without flush makes the filled word hit
      p_fill_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (fill && !flush) |=> (valid_q && tag_q == $past(fill_tag)));
   end else begin : g_none
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, look_tag, off, flush, fill,
                               fill_tag, fill_data};
      assign hit       = 1'b0;
      assign line_data = '0;
   end

endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
   import flash_seq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned WAIT_W     = 4,
   parameter int unsigned WAIT_RST   = 0,
   parameter bit          AUTO_RST   = 1'b1,
   parameter bit          CACHE_EN   = 1'b1,
   localparam int unsigned OFF_W     = $clog2(WORD_BYTES),
   localparam int unsigned WADDR_W   = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [WAIT_W-1:0]  cfg_wait_d,
   input  logic               cfg_auto_d,
   input  logic               cache_off,
   input  logic               pe_start,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   output logic               arr_req,
   output logic [WADDR_W-1:0] arr_addr,
   input  logic               arr_ready,
   input  logic [DATA_W-1:0]  arr_data
);

   if (!is_pow2(WORD_BYTES)) begin : g_bad_word
      $error("WORD_BYTES must be a power of two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the byte offset width");
   end
   if (WAIT_W < 1 || WAIT_RST >= (1 << WAIT_W)) begin : g_bad_wait
      $error("WAIT_W too small or WAIT_RST out of range");
   end

   fs_state_e          state;
   logic [WAIT_W-1:0]  wait_q;
   logic               auto_q;
   logic               ctr_zero;
   logic               cache_hit;
   logic [DATA_W-1:0]  line_data;
   logic               use_cache_q;
   logic [WADDR_W-1:0] look_tag;
   logic               accept;
   logic               done;
   logic               fill;

   assign look_tag  = req_addr[ADDR_W-1:OFF_W];
   assign req_ready = (state == FS_IDLE);
   assign accept    = req_valid && req_ready;
   assign done      = ((state == FS_PROG) && ctr_zero) ||
                      ((state == FS_AUTO) && arr_ready);
   assign fill      = done && use_cache_q;

   fseq_cfg_reg #(
      .WAIT_W   (WAIT_W),
      .WAIT_RST (WAIT_RST),
      .AUTO_RST (AUTO_RST)
   ) i_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .wait_d (cfg_wait_d),
      .auto_d (cfg_auto_d),
      .wait_q (wait_q),
      .auto_q (auto_q)
   );

   fseq_wait_ctr #(
      .CNT_W (WAIT_W)
   ) i_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (wait_q),
      .run      (state == FS_PROG),
      .zero     (ctr_zero)
   );

   fseq_line_cache #(
      .TAG_W    (WADDR_W),
      .DATA_W   (DATA_W),
      .CACHE_EN (CACHE_EN)
   ) i_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_tag  (look_tag),
      .off       (cache_off),
      .flush     (pe_start),
      .fill      (fill),
      .fill_tag  (arr_addr),
      .fill_data (arr_data),
      .hit       (cache_hit),
      .line_data (line_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= FS_IDLE;
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
         arr_req     <= 1'b0;
         arr_addr    <= '0;
         use_cache_q <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            FS_IDLE: begin
               if (accept) begin
                  if (cache_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= line_data;
                  end else begin
                     arr_req     <= 1'b1;
                     arr_addr    <= look_tag;
                     use_cache_q <= !cache_off;
                     state       <= auto_q ? FS_AUTO : FS_PROG;
                  end
               end
            end
            FS_PROG, FS_AUTO: begin
               if (done) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= arr_data;
                  arr_req   <= 1'b0;
                  state     <= FS_IDLE;
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   // R4: every accepted request either answers at once or starts an access
   p_accept_acts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (rsp_valid || arr_req));

   // R4: no new request is taken while the array is busy
   p_busy_not_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |-> !req_ready);

   // R5: a hit answers without touching the array
   p_hit_skips_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cache_hit) |=> (rsp_valid && !arr_req));

   // R6: with the cache bypassed the array is always used
   p_off_goes_array_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cache_off) |=> (arr_req && !rsp_valid));

   // R3: automatic mode adds at least one cycle
   p_auto_min_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && auto_q && !cache_hit) |=> !rsp_valid);

   // R3: automatic completion only on a sampled ready
   p_auto_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(state == FS_AUTO)) |-> $past(arr_ready));

   // R10: array address is stable during an access
   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && $past(arr_req)) |-> $stable(arr_addr));

endmodule

// File: tb/test_flash_rd_seq.sv
module test_flash_rd_seq;

   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int WAW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_wait_d = '0;
   logic          cfg_auto_d = 1'b0;
   logic          cache_off = 1'b0;
   logic          pe_start = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          arr_req;
   logic [WAW-1:0] arr_addr;
   logic          arr_ready;
   logic [DW-1:0] arr_data;

   int total = 0;
   int bad = 0;
   int unsigned gen = 0;
   int lat = 0;
   int age = 0;

   // bench model of configuration and line
   int          m_wait = 0;
   bit          m_auto = 1'b1;
   bit          m_off = 1'b0;
   bit          m_valid = 1'b0;
   logic [WAW-1:0] m_tag = '0;
   logic [DW-1:0]  m_data = '0;

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] arr_fn(logic [WAW-1:0] wa, int unsigned g);
      return (DW'(wa) * 32'h9E37_79B1) ^ (g * 32'h85EB_CA6B) ^ 32'h1234_5678;
   endfunction

   assign arr_data  = arr_fn(arr_addr, gen);
   assign arr_ready = arr_req && (age >= lat);

   always @(posedge clk) age <= arr_req ? age + 1 : 0;

   flash_rd_seq i_flash_rd_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wait_d (cfg_wait_d),
      .cfg_auto_d (cfg_auto_d),
      .cache_off  (cache_off),
      .pe_start   (pe_start),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .arr_req    (arr_req),
      .arr_addr   (arr_addr),
      .arr_ready  (arr_ready),
      .arr_data   (arr_data)
   );

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic cfg_write(int w, bit a);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wait_d = 4'(w); cfg_auto_d = a;
      @(negedge clk);
      cfg_we = 1'b0;
      m_wait = w; m_auto = a;
   endtask

   task automatic flush_line();
      @(negedge clk);
      pe_start = 1'b1;
      @(negedge clk);
      pe_start = 1'b0;
      gen++;
      m_valid = 1'b0;
   endtask

   task automatic set_off(bit v);
      @(negedge clk);
      cache_off = v;
      m_off = v;
   endtask

   // poke: reprogram the configuration (auto on, 0 waits) during the access
   task automatic do_read(logic [AW-1:0] addr, int l, bit poke, string tag);
      logic [WAW-1:0] wa;
      bit exp_hit;
      int exp_lat;
      logic [DW-1:0] exp_data;
      int got;
      int k;
      string rq;
      @(negedge clk);
      lat = l;
      wa = addr[AW-1:2];
      exp_hit = !m_off && m_valid && (m_tag == wa);
      exp_lat = exp_hit ? 0 : (m_auto ? l + 1 : m_wait + 1);
      exp_data = exp_hit ? m_data : arr_fn(wa, gen);
      rq = (tag != "") ? tag : exp_hit ? "R5" : m_off ? "R6" : m_auto ? "R3" : "R2";
      chk(req_ready == 1'b1, "R4", "ready before request", req_ready, 1);
      req_valid = 1'b1;
      req_addr = addr;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(arr_req == !exp_hit, "R10", "arr_req after accept", arr_req, !exp_hit);
      if (!exp_hit) chk(arr_addr == wa, "R10", "array word address", arr_addr, wa);
      got = -1;
      k = 0;
      while (k <= 40) begin
         if (rsp_valid) begin
            got = k;
            break;
         end
         if (poke && k == 1) begin
            cfg_we = 1'b1; cfg_wait_d = 4'd0; cfg_auto_d = 1'b1;
         end else begin
            cfg_we = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      cfg_we = 1'b0;
      if (poke) begin
         m_wait = 0; m_auto = 1'b1;
      end
      chk(got == exp_lat, rq, "response latency", got, exp_lat);
      chk(rsp_data == exp_data, exp_hit ? "R5" : "R10", "response data", rsp_data, exp_data);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R4", "pulse ends and ready returns",
          {rsp_valid, req_ready}, 2'b01);
      if (!exp_hit && !m_off) begin
         m_valid = 1'b1; m_tag = wa; m_data = exp_data;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
      chk(arr_req == 1'b0, "R1", "arr_req after reset", arr_req, 0);
      // R1: automatic mode is on after reset, latency follows the array
      do_read(16'h0100, 3, 1'b0, "R1");
      do_read(16'h0102, 0, 1'b0, "R5");
      // R9 + R2: programmed zero and fifteen waits
      cfg_write(0, 1'b0);
      do_read(16'h0200, 9, 1'b0, "R9");
      cfg_write(15, 1'b0);
      do_read(16'h0300, 0, 1'b0, "R2");
      do_read(16'h0301, 0, 1'b0, "R5");
      // R7: flush then re-read the same word
      flush_line();
      do_read(16'h0300, 0, 1'b0, "R7");
      // R6: bypass twice, then the untouched line hits again
      set_off(1'b1);
      do_read(16'h0300, 0, 1'b0, "R6");
      do_read(16'h0303, 0, 1'b0, "R6");
      set_off(1'b0);
      do_read(16'h0300, 0, 1'b0, "R5");
      // R8: mid-access reprogramming has no effect on that access
      cfg_write(6, 1'b0);
      do_read(16'h0400, 0, 1'b1, "R8");
      do_read(16'h0500, 2, 1'b0, "R9");
      // R3: minimum latency in automatic mode
      do_read(16'h0600, 0, 1'b0, "R3");
      // random mix
      for (int i = 0; i < 250; i++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op == 0) cfg_write(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
         else if (op == 1) flush_line();
         else if (op == 2) set_off(1'($urandom_range(0, 3) == 0));
         else do_read(AW'({$urandom_range(0, 3), 2'($urandom_range(0, 3))} + 16'h0800),
                      int'($urandom_range(0, 6)), 1'b0, "");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule